// File: doc/BRIEF.md
# Quad-Banked Unified Data Cache

This block is a unified data store for a dual-issue pipeline stage. It is divided into four banks, and address bits 5:4 pick the bank. Each bank holds four lines of four 32-bit words. The lines within a bank are fully associative, so an incoming tag is compared with every line of that bank. Two request ports feed the banks. Two requests that land in different banks are both served in the same cycle. Two requests that land in the same bank are serialized, and port 0 goes first.

Each bank can be switched on its own between cache behaviour and plain addressable RAM. A caching bank is write-back and fills through a line-wide external memory port that uses a valid/ready handshake. On a miss it first writes out a dirty victim and then fetches the new line. Victims are chosen round-robin within the bank. A bank in RAM mode skips the tag compare. It decodes the line and the word straight from the address and never touches external memory.

A requester holds its request stable until it sees done. Read data is valid during the done cycle. A write takes effect at the clock edge that closes its done cycle.

Top module: `quad_bank_cache`

## Requirements
- R1: The bank is given by address bits 5:4. Two requests that hit in different banks both assert done in the same cycle, with no external memory traffic.
- R2: When both ports request the same bank, port 0 is served. In that cycle p1Stall is 1 and p1Done is 0. Port 1 completes in the first cycle in which port 0 no longer requests that bank.
- R3: Address bits 3:2 select the word in a line. A hit completes in the cycle it is presented. A write hit changes only the addressed word, and a later read of that address returns the written value.
- R4: On a miss, the port raises busy and the line address (bits 15:4) is read over the memory port with memWe=0. The access completes in the cycle after that fill is acknowledged.
- R5: If the victim line is dirty, it is written out before the fill. The write carries memWe=1, memAddr set to the victim's own line address, and word k of the line in memWline bits 32k+31:32k. The fill line returned in memRline uses the same word layout.
- R6: Each bank has four line slots. Victims are chosen round-robin starting from slot 0 after reset, whatever hits have occurred.
- R7: Any four distinct lines that map to one bank can be resident at the same time.
- R8: When ramMode[b] is 1, bank b does no tag compare and causes no memory traffic. Address bits 7:6 pick the line and bits 3:2 pick the word. Bits above 7 are ignored, so addresses that differ only there alias. All storage reads as zero after reset.
- R9: During and right after reset, no done, busy, stall or memReq is asserted, and every cache line is invalid.
- R10: The mode is set per bank. A caching bank keeps its lines and hits while another bank is in RAM mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ramMode | input | 4 | Per-bank mode: 1 = addressable RAM, 0 = cache |
| p0Req | input | 1 | Port 0 request, held until done |
| p0We | input | 1 | Port 0 write (1) or read (0) |
| p0Addr | input | 14 | Port 0 byte address bits 15:2 |
| p0Wdata | input | 32 | Port 0 write data |
| p0Rdata | output | 32 | Port 0 read data, valid with done |
| p0Done | output | 1 | Port 0 access completes this cycle |
| p0Busy | output | 1 | Port 0 waiting on a miss service |
| p1Req | input | 1 | Port 1 request, held until done |
| p1We | input | 1 | Port 1 write (1) or read (0) |
| p1Addr | input | 14 | Port 1 byte address bits 15:2 |
| p1Wdata | input | 32 | Port 1 write data |
| p1Rdata | output | 32 | Port 1 read data, valid with done |
| p1Done | output | 1 | Port 1 access completes this cycle |
| p1Stall | output | 1 | Port 1 held by a same-bank conflict |
| p1Busy | output | 1 | Port 1 waiting on a miss service |
| memReq | output | 1 | External line transfer request |
| memWe | output | 1 | Transfer is a write-back (1) or fill (0) |
| memAddr | output | 12 | Line address, byte address bits 15:4 |
| memWline | output | 128 | Victim line data for write-back |
| memRline | input | 128 | Fill line data |
| memAck | input | 1 | Transfer accepted this cycle |

## Verification
- **Hits:** hit results are combinational. The bench reads them a short delay after the falling edge at which the request was applied, so they are checked in the same cycle.
- **Misses:** the bench's memory model acknowledges each request on the falling edge after it sees it. A miss with a clean victim therefore completes two cycles after it is presented, and one with a dirty victim after four. The bench counts falling edges until done and compares that count with twice the number of memory transfers it observed.
- **Writes:** write results are checked only by a later read.
- **Conflicts:** the same-bank case is sampled in the conflict cycle and again one cycle after port 0 is released.

// File: rtl/qbc_pkg.sv
package qbc_pkg;
  localparam int NBANK = 4;
  localparam int BK_W  = $clog2(NBANK);

  typedef enum logic [1:0] {S_IDLE, S_EVICT, S_FILL} svc_t;

  // strobes from control to the bank datapath
  typedef struct packed {
    logic            fill;   // load fill line into the victim slot
    logic [1:0]      wr;     // per-port write of the selected word
    logic [BK_W-1:0] mBank;  // bank whose victim is exposed / filled
  } strobe_t;
endpackage

// File: rtl/qbc_banks.sv
module qbc_banks
  import qbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32,
  parameter int LINES  = 4,
  parameter int WORDS  = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NBANK-1:0]                     ramMode,
  input  logic [1:0][ADDR_W-1:2]               addr,
  input  logic [1:0][WORD_W-1:0]               wdata,
  input  strobe_t                              ctl,
  input  logic [ADDR_W-$clog2(WORDS)-3-BK_W:0] fillTag,
  input  logic [WORDS*WORD_W-1:0]              fillLine,
  output logic [1:0]                           hit,
  output logic [1:0][WORD_W-1:0]               rdata,
  output logic                                 victimDirty,
  output logic [ADDR_W-$clog2(WORDS)-3:0]      victimAddr,
  output logic [WORDS*WORD_W-1:0]              victimLine
);
  localparam int WI_W  = $clog2(WORDS);
  localparam int OFF_W = WI_W + 2;
  localparam int LA_W  = ADDR_W - OFF_W;
  localparam int TAG_W = LA_W - BK_W;
  localparam int LI_W  = $clog2(LINES);

  logic [NBANK-1:0][LINES-1:0][WORDS-1:0][WORD_W-1:0] dataMem;
  logic [NBANK-1:0][LINES-1:0][TAG_W-1:0]             tagMem;
  logic [NBANK-1:0][LINES-1:0]                        valid;
  logic [NBANK-1:0][LINES-1:0]                        dirty;
  logic [NBANK-1:0][LI_W-1:0]                         rrPtr;

  logic [1:0][BK_W-1:0]  pBank;
  logic [1:0][WI_W-1:0]  pWord;
  logic [1:0][LI_W-1:0]  lineSel;
  logic [1:0][LINES-1:0] match;
  logic [LI_W-1:0]       victimIdx;

  // lookup for both ports
  always_comb begin
    for (int p = 0; p < 2; p++) begin
      pBank[p]   = addr[p][OFF_W +: BK_W];
      pWord[p]   = addr[p][2 +: WI_W];
      match[p]   = '0;
      lineSel[p] = '0;
      for (int l = 0; l < LINES; l++)
        match[p][l] = valid[pBank[p]][l] &&
                      (tagMem[pBank[p]][l] == addr[p][ADDR_W-1 -: TAG_W]);
      if (ramMode[pBank[p]]) begin
        lineSel[p] = addr[p][OFF_W+BK_W +: LI_W];
      end else begin
        for (int l = 0; l < LINES; l++)
          if (match[p][l]) lineSel[p] = LI_W'(l);
      end
      hit[p]   = ramMode[pBank[p]] || (|match[p]);
      rdata[p] = dataMem[pBank[p]][lineSel[p]][pWord[p]];
    end
  end

  // victim of the bank under service
  always_comb begin
    victimIdx   = rrPtr[ctl.mBank];
    victimDirty = valid[ctl.mBank][victimIdx] && dirty[ctl.mBank][victimIdx];
    victimAddr  = {tagMem[ctl.mBank][victimIdx], ctl.mBank};
    victimLine  = dataMem[ctl.mBank][victimIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataMem <= '0;
      tagMem  <= '0;
      valid   <= '0;
      dirty   <= '0;
      rrPtr   <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (ctl.wr[p]) begin
          dataMem[pBank[p]][lineSel[p]][pWord[p]] <= wdata[p];
          if (!ramMode[pBank[p]]) dirty[pBank[p]][lineSel[p]] <= 1'b1;
        end
      end
      if (ctl.fill) begin
        dataMem[ctl.mBank][victimIdx] <= fillLine;
        tagMem[ctl.mBank][victimIdx]  <= fillTag;
        valid[ctl.mBank][victimIdx]   <= 1'b1;
        dirty[ctl.mBank][victimIdx]   <= 1'b0;
        rrPtr[ctl.mBank]              <= victimIdx + 1'b1;
      end
    end
  end

  // R7: tags inside a bank never duplicate, so at most one line matches
  for (genvar p = 0; p < 2; p++) begin : g_chk
    a_r7_single_match: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(match[p]));
  end

  // R6: a fill moves the victim pointer of that bank on by one slot
  a_r6_round_robin: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fill |=> (rrPtr[$past(ctl.mBank)] == LI_W'($past(victimIdx) + 1'b1)));

  // R5: a filled line starts clean and valid
  a_r5_fill_clean: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fill |=> (valid[$past(ctl.mBank)][$past(victimIdx)] &&
                  !dirty[$past(ctl.mBank)][$past(victimIdx)]));
endmodule

// File: rtl/qbc_ctrl.sv
module qbc_ctrl
  import qbc_pkg::*;
#(
  parameter int LA_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NBANK-1:0]     ramMode,
  input  logic [1:0]           req,
  input  logic [1:0]           we,
  input  logic [1:0][LA_W-1:0] lineAddr,
  input  logic [1:0]           hit,
  input  logic                 victimDirty,
  input  logic                 memAck,
  output logic [1:0]           done,
  output logic                 stall1,
  output logic [1:0]           busy,
  output strobe_t              ctl,
  output logic [LA_W-1:0]      missLine,
  output logic                 memReq,
  output logic                 memWe
);
  svc_t                 state;
  logic [1:0][BK_W-1:0] bank;
  logic [BK_W-1:0]      svcBank;
  logic [1:0]           blk;
  logic [1:0]           gnt;
  logic [1:0]           miss;
  logic                 sameBank;

  always_comb begin
    svcBank = missLine[BK_W-1:0];
    for (int p = 0; p < 2; p++) begin
      bank[p] = lineAddr[p][BK_W-1:0];
      blk[p]  = (state != S_IDLE) && (bank[p] == svcBank);
    end
    sameBank  = bank[0] == bank[1];
    stall1    = req[1] && req[0] && sameBank;
    gnt[0]    = req[0] && !blk[0];
    gnt[1]    = req[1] && !blk[1] && !stall1;
    done      = gnt & hit;
    miss      = gnt & ~hit;
    busy[0]   = req[0] && !done[0];
    busy[1]   = req[1] && !done[1] && !stall1;
    ctl.fill  = (state == S_FILL) && memAck;
    ctl.wr    = done & we;
    ctl.mBank = (state == S_IDLE) ? (miss[0] ? bank[0] : bank[1]) : svcBank;
    memReq    = state != S_IDLE;
    memWe     = state == S_EVICT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      missLine <= '0;
    end else begin
      case (state)
        S_IDLE: if (|miss) begin
          missLine <= miss[0] ? lineAddr[0] : lineAddr[1];
          state    <= victimDirty ? S_EVICT : S_FILL;
        end
        S_EVICT: if (memAck) state <= S_FILL;
        S_FILL:  if (memAck) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: one bank never completes two accesses in a cycle
  a_r2_bank_conflict: assert property (@(posedge clk) disable iff (!rstN)
    (req[0] && req[1] && sameBank) |-> !done[1]);

  // R1: idle service and two hits in separate banks both finish
  a_r1_parallel: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && req[0] && req[1] && !sameBank && hit[0] && hit[1])
      |-> (done[0] && done[1]));

  // R4: an acknowledged fill ends the service
  a_r4_fill_ends: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FILL && memAck) |=> (state == S_IDLE));

  // R5: write-back always precedes a fill
  a_r5_evict_first: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EVICT && memAck) |=> (memReq && !memWe));

  // R8: a RAM-mode bank request on port 0 completes at once
  a_r8_ram_direct: assert property (@(posedge clk) disable iff (!rstN)
    (req[0] && ramMode[bank[0]] && state == S_IDLE) |-> done[0]);
endmodule

// File: rtl/quad_bank_cache.sv
module quad_bank_cache
  import qbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32,
  parameter int LINES  = 4,
  parameter int WORDS  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NBANK-1:0]          ramMode,
  input  logic                      p0Req,
  input  logic                      p0We,
  input  logic [ADDR_W-1:2]         p0Addr,
  input  logic [WORD_W-1:0]         p0Wdata,
  output logic [WORD_W-1:0]         p0Rdata,
  output logic                      p0Done,
  output logic                      p0Busy,
  input  logic                      p1Req,
  input  logic                      p1We,
  input  logic [ADDR_W-1:2]         p1Addr,
  input  logic [WORD_W-1:0]         p1Wdata,
  output logic [WORD_W-1:0]         p1Rdata,
  output logic                      p1Done,
  output logic                      p1Stall,
  output logic                      p1Busy,
  output logic                      memReq,
  output logic                      memWe,
  output logic [ADDR_W-1:$clog2(WORDS)+2] memAddr,
  output logic [WORDS*WORD_W-1:0]   memWline,
  input  logic [WORDS*WORD_W-1:0]   memRline,
  input  logic                      memAck
);
  localparam int OFF_W = $clog2(WORDS) + 2;
  localparam int LA_W  = ADDR_W - OFF_W;

  logic [1:0][ADDR_W-1:2] addr;
  logic [1:0][WORD_W-1:0] wdata, rdata;
  logic [1:0][LA_W-1:0]   lineAddr;
  logic [1:0]             hit, done, busy;
  logic                   victimDirty;
  logic [LA_W-1:0]        victimAddr, missLine;
  strobe_t                ctl;

  assign addr     = {p1Addr, p0Addr};
  assign wdata    = {p1Wdata, p0Wdata};
  assign lineAddr = {p1Addr[ADDR_W-1:OFF_W], p0Addr[ADDR_W-1:OFF_W]};
  assign p0Rdata  = rdata[0];
  assign p1Rdata  = rdata[1];
  assign p0Done   = done[0];
  assign p1Done   = done[1];
  assign p0Busy   = busy[0];
  assign p1Busy   = busy[1];
  assign memAddr  = memWe ? victimAddr : missLine;

  qbc_ctrl #(.LA_W(LA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .ramMode(ramMode),
    .req({p1Req, p0Req}), .we({p1We, p0We}), .lineAddr(lineAddr),
    .hit(hit), .victimDirty(victimDirty), .memAck(memAck),
    .done(done), .stall1(p1Stall), .busy(busy), .ctl(ctl),
    .missLine(missLine), .memReq(memReq), .memWe(memWe)
  );

  qbc_banks #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINES(LINES), .WORDS(WORDS)) i_banks (
    .clk(clk), .rstN(rstN), .ramMode(ramMode), .addr(addr), .wdata(wdata),
    .ctl(ctl), .fillTag(missLine[LA_W-1:BK_W]), .fillLine(memRline),
    .hit(hit), .rdata(rdata), .victimDirty(victimDirty),
    .victimAddr(victimAddr), .victimLine(memWline)
  );
endmodule

// File: tb/test_quad_bank_cache.sv
module test_quad_bank_cache;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0;
  logic         rstN;
  logic [3:0]   ramMode;
  logic         p0Req, p0We, p1Req, p1We;
  logic [15:2]  p0Addr, p1Addr;
  logic [31:0]  p0Wdata, p1Wdata, p0Rdata, p1Rdata;
  logic         p0Done, p0Busy, p1Done, p1Stall, p1Busy;
  logic         memReq, memWe, memAck;
  logic [15:4]  memAddr;
  logic [127:0] memWline, memRline;

  int total = 0, bad = 0;
  int txnCount = 0, wbCount = 0;
  logic [15:4]  lastWbAddr;
  logic [127:0] lastWbLine;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_bank_cache i_quad_bank_cache (
    .clk(clk), .rstN(rstN), .ramMode(ramMode),
    .p0Req(p0Req), .p0We(p0We), .p0Addr(p0Addr), .p0Wdata(p0Wdata),
    .p0Rdata(p0Rdata), .p0Done(p0Done), .p0Busy(p0Busy),
    .p1Req(p1Req), .p1We(p1We), .p1Addr(p1Addr), .p1Wdata(p1Wdata),
    .p1Rdata(p1Rdata), .p1Done(p1Done), .p1Stall(p1Stall), .p1Busy(p1Busy),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWline(memWline), .memRline(memRline), .memAck(memAck)
  );

  // memory word pattern: A500_0000 plus the byte address of the word
  function automatic logic [127:0] patLine(logic [15:4] la);
    for (int w = 0; w < 4; w++)
      patLine[32*w +: 32] = {16'hA500, la, w[1:0], 2'b00};
  endfunction

  // memory model: acknowledges on the falling edge after seeing a request
  initial begin
    memAck = 0; memRline = '0;
    forever begin
      @(negedge clk);
      if (memReq && !memAck) begin
        memAck   = 1;
        memRline = patLine(memAddr);
        txnCount++;
        if (memWe) begin
          wbCount++; lastWbAddr = memAddr; lastWbLine = memWline;
        end
      end else memAck = 0;
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic string reqName(input logic [3:0] n);
    case (n)
      1: reqName = "R1";  2: reqName = "R2";  3: reqName = "R3";
      4: reqName = "R4";  5: reqName = "R5";  6: reqName = "R6";
      7: reqName = "R7";  8: reqName = "R8";  9: reqName = "R9";
      default: reqName = "R10";
    endcase
  endfunction

  task automatic access0(input logic we, input logic [15:0] a, input logic [31:0] wd,
                         output logic [31:0] rd, output int cyc, output bit sawBusy);
    @(negedge clk);
    p0Req = 1; p0We = we; p0Addr = a[15:2]; p0Wdata = wd;
    cyc = 0; sawBusy = 0;
    #1;
    while (!p0Done && cyc < 40) begin
      if (p0Busy) sawBusy = 1;
      @(negedge clk); #1; cyc++;
    end
    rd = p0Rdata;
    @(posedge clk); #1;
    p0Req = 0; p0We = 0;
  endtask

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [31:0] expData;
    logic        chk;
    logic [1:0]  txn;
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{1'b0, 16'h0000, 32'h0,        32'hA5000000, 1'b1, 2'd1, 4'd4},
    '{1'b1, 16'h0004, 32'h11111111, 32'h0,        1'b0, 2'd0, 4'd3},
    '{1'b0, 16'h0004, 32'h0,        32'h11111111, 1'b1, 2'd0, 4'd3},
    '{1'b0, 16'h0100, 32'h0,        32'hA5000100, 1'b1, 2'd1, 4'd7},
    '{1'b0, 16'h0208, 32'h0,        32'hA5000208, 1'b1, 2'd1, 4'd7},
    '{1'b0, 16'h0F0C, 32'h0,        32'hA5000F0C, 1'b1, 2'd1, 4'd7},
    '{1'b0, 16'h0104, 32'h0,        32'hA5000104, 1'b1, 2'd0, 4'd7},
    '{1'b0, 16'h0010, 32'h0,        32'hA5000010, 1'b1, 2'd1, 4'd1},
    '{1'b0, 16'h1000, 32'h0,        32'hA5001000, 1'b1, 2'd2, 4'd5},
    '{1'b0, 16'h0000, 32'h0,        32'hA5000000, 1'b1, 2'd1, 4'd6},
    '{1'b0, 16'h0108, 32'h0,        32'hA5000108, 1'b1, 2'd1, 4'd6},
    '{1'b0, 16'h0F00, 32'h0,        32'hA5000F00, 1'b1, 2'd0, 4'd6},
    '{1'b0, 16'h0208, 32'h0,        32'hA5000208, 1'b1, 2'd1, 4'd6}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int cyc, t0;
    bit sb;
    rstN = 0; ramMode = 4'b0000;
    p0Req = 0; p0We = 0; p0Addr = '0; p0Wdata = '0;
    p1Req = 0; p1We = 0; p1Addr = '0; p1Wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1; #1;
    // R9: quiet after reset
    check({p0Done, p0Busy, p1Done, p1Stall, p1Busy, memReq} == 6'b0, "R9",
          "outputs idle after reset", {p0Done, p0Busy, p1Done, p1Stall, p1Busy, memReq}, 0);

    // table walk (port 0); R4 latency: 2 cycles per memory transfer
    for (int i = 0; i < 13; i++) begin
      t0 = txnCount;
      access0(VECS[i].we, VECS[i].addr, VECS[i].wdata, rd, cyc, sb);
      if (VECS[i].chk)
        check(rd == VECS[i].expData, reqName(VECS[i].rq), $sformatf("vec %0d data", i),
              rd, VECS[i].expData);
      check(txnCount - t0 == int'(VECS[i].txn), reqName(VECS[i].rq),
            $sformatf("vec %0d transfers", i), txnCount - t0, VECS[i].txn);
      check(cyc == 2 * int'(VECS[i].txn), "R4", $sformatf("vec %0d latency", i),
            cyc, 2 * VECS[i].txn);
      if (VECS[i].txn != 0)
        check(sb, "R4", $sformatf("vec %0d busy during miss", i), sb, 1);
    end

    // R5: the single write-back carried the dirty line 0x000
    check(wbCount == 1, "R5", "write-back count", wbCount, 1);
    check(lastWbAddr == 12'h000, "R5", "write-back address", lastWbAddr, 0);
    check(lastWbLine[63:0] == 64'h11111111_A5000000, "R5", "write-back data",
          lastWbLine[63:0], 64'h11111111_A5000000);

    // R1: hits in bank 0 and bank 1 finish together
    @(negedge clk);
    p0Req = 1; p0Addr = 14'(16'h0104 >> 2); p1Req = 1; p1Addr = 14'(16'h0010 >> 2);
    #1;
    check(p0Done && p1Done, "R1", "parallel done", {p0Done, p1Done}, 2'b11);
    check(p0Rdata == 32'hA5000104 && p1Rdata == 32'hA5000010, "R1", "parallel data",
          {p0Rdata, p1Rdata}, {32'hA5000104, 32'hA5000010});
    @(posedge clk); #1; p0Req = 0; p1Req = 0;

    // R2: same-bank conflict
    @(negedge clk);
    p0Req = 1; p0Addr = 14'(16'h0104 >> 2); p1Req = 1; p1Addr = 14'(16'h0000 >> 2);
    #1;
    check(p0Done && !p1Done && p1Stall, "R2", "conflict cycle",
          {p0Done, p1Done, p1Stall}, 3'b101);
    @(posedge clk); #1; p0Req = 0;
    @(negedge clk); #1;
    check(p1Done && !p1Stall && p1Rdata == 32'hA5000000, "R2", "port 1 next cycle",
          {p1Done, p1Stall, p1Rdata}, {2'b10, 32'hA5000000});
    @(posedge clk); #1; p1Req = 0;

    // R8: bank 2 as RAM
    @(negedge clk); ramMode = 4'b0100;
    t0 = txnCount;
    access0(1'b0, 16'h0028, 32'h0, rd, cyc, sb);
    check(rd == 32'h0, "R8", "RAM reads zero after reset", rd, 0);
    access0(1'b1, 16'h0024, 32'hCAFE0001, rd, cyc, sb);
    access0(1'b0, 16'hFF24, 32'h0, rd, cyc, sb);
    check(rd == 32'hCAFE0001, "R8", "upper bits alias", rd, 32'hCAFE0001);
    access0(1'b1, 16'h00E8, 32'h0BAD0002, rd, cyc, sb);
    access0(1'b0, 16'h00E8, 32'h0, rd, cyc, sb);
    check(rd == 32'h0BAD0002, "R8", "line 3 word 2", rd, 32'h0BAD0002);
    access0(1'b0, 16'h0024, 32'h0, rd, cyc, sb);
    check(rd == 32'hCAFE0001, "R8", "line 0 untouched", rd, 32'hCAFE0001);
    check(txnCount == t0, "R8", "no memory traffic", txnCount - t0, 0);
    // R10: bank 0 still caching
    access0(1'b0, 16'h0104, 32'h0, rd, cyc, sb);
    check(rd == 32'hA5000104 && cyc == 0 && txnCount == t0, "R10", "cache bank hit",
          {rd, 8'(cyc)}, {32'hA5000104, 8'd0});

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule